// File: doc/BRIEF.md
# Serial Scan Chain Engine

This block drives an internal serial configuration chain for several lane groups from two registers that software writes. The control register holds a clock-divide exponent, the index of the group whose returning bit feeds the engine, and a per-group bypass mask. The command register holds a 32-bit shift word, a bit count and a one-hot group select, plus three command bits: shift, update and capture.

A shift moves 1 to 32 bits out of the low end of the shift word into every selected chain. At the same time, the bits coming back from the indexed group enter at the high end of the word. Each group's chain is LANES x LANE_LEN bits long and closes a ring with the engine's shift word. An update copies each selected chain into the lane holding registers of that group. A capture copies the lane registers back into the chain. Each command bit clears itself when its operation ends, so software polls that bit to know when the operation is complete. Bit moves happen at the rate of a divided shift clock, which the block also drives out.

Top module: `scan_chain_engine`

## Requirements
- R1: After reset, both registers read zero (shift word, count, select, command bits, exponent, index and mask), the lane outputs are zero, every chain holds zero and the shift clock output is low.
- R2: While a command runs with exponent d (control bits [2:0]), one bit step occurs every 2^(d+2) system clocks. The shift clock output is low for the first half of each step period and high for the second half. It is low while the engine is idle.
- R3: The count field (command bits [36:32]) holds the number of bits minus one. A shift of n bits (1..32) ends, and the busy command bit reads zero, exactly n*2^(d+2) cycles after the clock edge that accepted the write.
- R4: On each step, bit 0 of the shift word (command bits [31:0]) enters each selected chain, and the word moves down by one. The bit returning from the indexed group enters bit 31. After n steps, the returned bits occupy the top n bits, with the oldest returned bit lowest.
- R5: The chain and the shift word form a ring. Shifting CHAIN_LEN bits returns the chain's previous contents in the order they entered it.
- R6: Command bits read back as shift=bit 40, update=bit 41 and capture=bit 42. While a command runs, the shift word and count read their live values, and the count drops by one per step. When a shift ends, its count reads all ones.
- R7: An update, which takes one step period, copies each selected group's chain into that group's lane outputs. Unselected groups keep their lane values.
- R8: A capture, which takes one step period, reloads each selected group's chain from its lane registers.
- R9: A command-register write made while a command runs is ignored in full: its word, count, select and command bits have no effect.
- R10: If a write sets several command bits, only one runs, chosen in the order shift, then update, then capture. It alone reads back as set.
- R11: A group whose bypass bit (control bit 16+g) is set acts as a one-bit delay during a shift. Its chain contents stay unchanged.
- R12: Only groups whose bit is set in the one-hot select (command bits [51:48]) move or update. The returned bit comes from the group named by the index field (control bits [9:8]).
- R13: A control-register write made while a command runs is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 control, 1 command |
| wr_data_i | input | 64 | Write data |
| rd_sel_i | input | 1 | Read source: 0 control, 1 command |
| rd_data_o | output | 64 | Read data, combinational from rd_sel_i |
| scan_clk_o | output | 1 | Divided shift clock |
| lanes_o | output | NUM_GRP*LANES*LANE_LEN | Lane holding registers, group 0 in the low bits |

## Verification
A write takes effect at the clock edge that samples the strobe, and its readback appears in the following cycle. A bit step falls 2^(d+2) cycles after the accepting edge and repeats at that interval. A shift of n bits therefore clears its command bit after n*2^(d+2) edges, and an update or capture clears after one step period. The bench drives inputs shortly after the rising edge and compares the read port, the lanes and the shift clock against a behavioural model at every falling edge. The directed checks count falling edges from the accepting edge until the command bit drops, so each duration is measured against the formula above.

// File: rtl/scan_pkg.sv
package scan_pkg;
  // control register layout
  localparam int DIV_LSB = 0;
  localparam int MUX_LSB = 8;
  localparam int BYP_LSB = 16;
  // command register layout
  localparam int SR_LSB    = 0;
  localparam int CNT_LSB   = 32;
  localparam int SHIFT_BIT = 40;
  localparam int UPD_BIT   = 41;
  localparam int CAP_BIT   = 42;
  localparam int SEL_LSB   = 48;
  localparam int REG_W     = 64;

  typedef enum logic [1:0] {
    OP_IDLE    = 2'd0,
    OP_SHIFT   = 2'd1,
    OP_UPDATE  = 2'd2,
    OP_CAPTURE = 2'd3
  } op_e;
endpackage

// File: rtl/scan_clk_div.sv
module scan_clk_div #(
  parameter int DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o,
  output logic             sclk_o
);
  localparam int CNT_W = (1 << DIV_W) + 2;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;
  logic [CNT_W-1:0] half;
  logic [DIV_W:0]   div_x;

  assign div_x  = {1'b0, div_i};
  assign last   = (CNT_W'(1) << (div_x + (DIV_W+1)'(2))) - CNT_W'(1);
  assign half   = CNT_W'(1) << (div_x + (DIV_W+1)'(1));
  assign tick_o = run_i && (cnt_q == last);
  assign sclk_o = run_i && ((cnt_q & half) != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + CNT_W'(1);
  end

  // R2: a new step period starts in its low half
  a_r2_clk_low_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !sclk_o);
  a_r2_idle_clk_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !sclk_o);
endmodule

// File: rtl/scan_chain_grp.sv
module scan_chain_grp #(
  parameter int LANES    = 4,
  parameter int LANE_LEN = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      sel_i,
  input  logic                      bypass_i,
  input  logic                      shift_i,
  input  logic                      update_i,
  input  logic                      capture_i,
  input  logic                      din_i,
  output logic                      dout_o,
  output logic [LANES*LANE_LEN-1:0] lanes_o
);
  localparam int CHAIN_LEN = LANES * LANE_LEN;

  logic [CHAIN_LEN-1:0] chain_q;
  logic                 dly_q;

  assign dout_o = bypass_i ? dly_q : chain_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      dly_q   <= 1'b0;
    end else if (sel_i) begin
      if (shift_i) begin
        if (bypass_i) dly_q   <= din_i;
        else          chain_q <= {din_i, chain_q[CHAIN_LEN-1:1]};
      end else if (capture_i) begin
        chain_q <= lanes_o;
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_LEN-1:0] seg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                seg_q <= '0;
      else if (sel_i && update_i) seg_q <= chain_q[l*LANE_LEN +: LANE_LEN];
    end
    assign lanes_o[l*LANE_LEN +: LANE_LEN] = seg_q;
  end

  a_r11_bypass_freezes_chain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && shift_i && bypass_i) |=> $stable(chain_q));
  a_r7_update_copies_chain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && update_i) |=> (lanes_o == $past(chain_q)));
  a_r12_unselected_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> ($stable(chain_q) && $stable(lanes_o)));
endmodule

// File: rtl/scan_chain_engine.sv
module scan_chain_engine
  import scan_pkg::*;
#(
  parameter int NUM_GRP  = 4,
  parameter int LANES    = 4,
  parameter int LANE_LEN = 8,
  parameter int SR_W     = 32,
  parameter int DIV_W    = 3
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic                              wr_sel_i,
  input  logic [63:0]                       wr_data_i,
  input  logic                              rd_sel_i,
  output logic [63:0]                       rd_data_o,
  output logic                              scan_clk_o,
  output logic [NUM_GRP*LANES*LANE_LEN-1:0] lanes_o
);
  localparam int CHAIN_LEN = LANES * LANE_LEN;
  localparam int MUX_W     = $clog2(NUM_GRP);
  localparam int CNT_W     = $clog2(SR_W);

  logic [DIV_W-1:0]   div_q;
  logic [MUX_W-1:0]   mux_q;
  logic [NUM_GRP-1:0] byp_q;
  logic [SR_W-1:0]    sr_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [NUM_GRP-1:0] sel_q;
  op_e                op_q;
  op_e                new_op;
  logic               busy;
  logic               tick;
  logic               ret_bit;
  logic [NUM_GRP-1:0] grp_dout;
  logic               unused_wr;

  assign busy      = (op_q != OP_IDLE);
  assign ret_bit   = grp_dout[mux_q];
  assign unused_wr = ^wr_data_i;

  always_comb begin
    if (wr_data_i[SHIFT_BIT])    new_op = OP_SHIFT;
    else if (wr_data_i[UPD_BIT]) new_op = OP_UPDATE;
    else if (wr_data_i[CAP_BIT]) new_op = OP_CAPTURE;
    else                         new_op = OP_IDLE;
  end

  scan_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .div_i  (div_q),
    .tick_o (tick),
    .sclk_o (scan_clk_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      mux_q <= '0;
      byp_q <= '0;
      sr_q  <= '0;
      cnt_q <= '0;
      sel_q <= '0;
      op_q  <= OP_IDLE;
    end else if (busy) begin
      if (tick) begin
        if (op_q == OP_SHIFT) begin
          sr_q  <= {ret_bit, sr_q[SR_W-1:1]};
          cnt_q <= cnt_q - CNT_W'(1);
          if (cnt_q == '0) op_q <= OP_IDLE;
        end else begin
          op_q <= OP_IDLE;
        end
      end
    end else if (wr_en_i) begin
      if (wr_sel_i) begin
        sr_q  <= wr_data_i[SR_LSB +: SR_W];
        cnt_q <= wr_data_i[CNT_LSB +: CNT_W];
        sel_q <= wr_data_i[SEL_LSB +: NUM_GRP];
        op_q  <= new_op;
      end else begin
        div_q <= wr_data_i[DIV_LSB +: DIV_W];
        mux_q <= wr_data_i[MUX_LSB +: MUX_W];
        byp_q <= wr_data_i[BYP_LSB +: NUM_GRP];
      end
    end
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    scan_chain_grp #(.LANES(LANES), .LANE_LEN(LANE_LEN)) u_grp (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sel_i     (sel_q[g]),
      .bypass_i  (byp_q[g]),
      .shift_i   (tick && op_q == OP_SHIFT),
      .update_i  (tick && op_q == OP_UPDATE),
      .capture_i (tick && op_q == OP_CAPTURE),
      .din_i     (sr_q[0]),
      .dout_o    (grp_dout[g]),
      .lanes_o   (lanes_o[g*CHAIN_LEN +: CHAIN_LEN])
    );
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_sel_i) begin
      rd_data_o[SR_LSB +: SR_W]     = sr_q;
      rd_data_o[CNT_LSB +: CNT_W]   = cnt_q;
      rd_data_o[SEL_LSB +: NUM_GRP] = sel_q;
      rd_data_o[SHIFT_BIT]          = (op_q == OP_SHIFT);
      rd_data_o[UPD_BIT]            = (op_q == OP_UPDATE);
      rd_data_o[CAP_BIT]            = (op_q == OP_CAPTURE);
    end else begin
      rd_data_o[DIV_LSB +: DIV_W]   = div_q;
      rd_data_o[MUX_LSB +: MUX_W]   = mux_q;
      rd_data_o[BYP_LSB +: NUM_GRP] = byp_q;
    end
  end

  a_r3_last_step_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == OP_SHIFT && tick && cnt_q == '0) |=> (op_q == OP_IDLE));
  a_r9_busy_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && wr_en_i && wr_sel_i) |=> $stable(sel_q));
  a_r13_busy_ctrl_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> ($stable(div_q) && $stable(mux_q) && $stable(byp_q)));
  a_r6_hold_between_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !tick) |=> ($stable(cnt_q) && $stable(sr_q)));
endmodule

// File: tb/tb_scan_chain_engine.sv
module tb_scan_chain_engine;
  localparam int NG = 4;
  localparam int CL = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [63:0] wr_data = '0;
  logic        rd_sel = 1'b1;
  logic [63:0] rd_data;
  logic        scan_clk;
  logic [NG*CL-1:0] lanes;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  scan_chain_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .scan_clk_o(scan_clk), .lanes_o(lanes)
  );

  // behavioural reference model
  int          m_div, m_mux, m_op, m_pc;
  logic [3:0]  m_byp, m_bq, m_sel;
  logic [31:0] m_sr;
  logic [4:0]  m_cnt;
  logic [31:0] m_chain [NG];
  logic [31:0] m_lane [NG];

  task automatic m_reset();
    m_div = 0; m_mux = 0; m_op = 0; m_pc = 0;
    m_byp = '0; m_bq = '0; m_sel = '0; m_sr = '0; m_cnt = '0;
    for (int g = 0; g < NG; g++) begin m_chain[g] = '0; m_lane[g] = '0; end
  endtask

  initial m_reset();

  always @(posedge clk) begin : model
    int p;
    logic ob, rb;
    if (!rst_n) m_reset();
    else if (m_op != 0) begin
      p = 1 << (m_div + 2);
      if (m_pc == p - 1) begin
        m_pc = 0;
        if (m_op == 1) begin
          ob = m_sr[0];
          rb = m_byp[m_mux] ? m_bq[m_mux] : m_chain[m_mux][0];
          for (int g = 0; g < NG; g++)
            if (m_sel[g]) begin
              if (m_byp[g]) m_bq[g] = ob;
              else m_chain[g] = {ob, m_chain[g][31:1]};
            end
          m_sr = {rb, m_sr[31:1]};
          if (m_cnt == 0) m_op = 0;
          m_cnt = m_cnt - 5'd1;
        end else begin
          for (int g = 0; g < NG; g++)
            if (m_sel[g]) begin
              if (m_op == 2) m_lane[g] = m_chain[g];
              else m_chain[g] = m_lane[g];
            end
          m_op = 0;
        end
      end else m_pc++;
    end else if (wr_en) begin
      if (wr_sel) begin
        m_sr = wr_data[31:0]; m_cnt = wr_data[36:32]; m_sel = wr_data[51:48];
        m_op = wr_data[40] ? 1 : wr_data[41] ? 2 : wr_data[42] ? 3 : 0;
        m_pc = 0;
      end else begin
        m_div = int'(wr_data[2:0]); m_mux = int'(wr_data[9:8]); m_byp = wr_data[19:16];
      end
    end
  end

  function automatic logic [63:0] m_rd(logic s);
    logic [63:0] r = '0;
    if (s) begin
      r[31:0] = m_sr; r[36:32] = m_cnt; r[51:48] = m_sel;
      r[40] = (m_op == 1); r[41] = (m_op == 2); r[42] = (m_op == 3);
    end else begin
      r[2:0] = m_div[2:0]; r[9:8] = m_mux[1:0]; r[19:16] = m_byp;
    end
    return r;
  endfunction

  task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin : cmp
    logic sc;
    if (rst_n && !done) begin
      sc = (m_op != 0) && (m_pc >= (1 << (m_div + 1)));
      chk(rd_data == m_rd(rd_sel), "R4 R6 model read", 128'(rd_data), 128'(m_rd(rd_sel)));
      chk(lanes == {m_lane[3], m_lane[2], m_lane[1], m_lane[0]}, "R7 R8 model lanes",
          lanes, {m_lane[3], m_lane[2], m_lane[1], m_lane[0]});
      chk(scan_clk == sc, "R2 model scan clock", 128'(scan_clk), 128'(sc));
    end
  end

  function automatic logic [63:0] ctrlw(int d, int mx, logic [3:0] b);
    return (64'(b) << 16) | (64'(mx) << 8) | 64'(d);
  endfunction

  function automatic logic [63:0] cmdw(logic [31:0] sr, int n, logic [2:0] c, logic [3:0] s);
    return (64'(s) << 48) | (64'(c) << 40) | (64'(n - 1) << 32) | 64'(sr);
  endfunction

  task automatic wr(logic s, logic [63:0] d);
    @(posedge clk); #2;
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  // waits for the command bits to drop; returns edges since the accepting edge
  task automatic wait_idle(output int cyc, output int hi);
    cyc = 0; hi = 0;
    rd_sel = 1'b1;
    forever begin
      @(negedge clk);
      if (rd_data[42:40] == 3'b000) break;
      if (scan_clk) hi++;
      cyc++;
    end
  endtask

  task automatic run(logic [63:0] d, output int cyc, output int hi);
    wr(1'b1, d);
    wait_idle(cyc, hi);
  endtask

  task automatic rd_ctrl(output logic [63:0] v);
    @(posedge clk); #2; rd_sel = 1'b0;
    @(negedge clk); v = rd_data;
    #1 rd_sel = 1'b1;
  endtask

  initial begin : wdog
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    int cyc, hi;
    logic [63:0] v;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(rd_data == 64'h0, "R1 command reg after reset", 128'(rd_data), 128'h0);
    chk(lanes == '0, "R1 lanes after reset", lanes, 128'h0);
    chk(scan_clk == 1'b0, "R1 scan clock after reset", 128'(scan_clk), 128'h0);
    rd_ctrl(v);
    chk(v == 64'h0, "R1 control reg after reset", 128'(v), 128'h0);

    // div 0, index 0, no bypass: fill group 0
    wr(1'b0, ctrlw(0, 0, 4'h0));
    run(cmdw(32'hDEADBEEF, 32, 3'b001, 4'b0001), cyc, hi);
    chk(cyc == 128, "R3 32-bit shift duration", 128'(cyc), 128'd128);
    chk(hi == 64, "R2 scan clock high cycles", 128'(hi), 128'd64);
    chk(rd_data[31:0] == 32'h0, "R5 empty chain returns zero", 128'(rd_data[31:0]), 128'h0);
    chk(rd_data[36:32] == 5'h1f, "R6 count wraps to all ones", 128'(rd_data[36:32]), 128'h1f);

    run(cmdw(32'h12345678, 32, 3'b001, 4'b0001), cyc, hi);
    chk(rd_data[31:0] == 32'hDEADBEEF, "R5 ring returns previous word", 128'(rd_data[31:0]), 128'hDEADBEEF);

    run(cmdw(32'h0, 1, 3'b010, 4'b0001), cyc, hi);
    chk(cyc == 4, "R7 update duration", 128'(cyc), 128'd4);
    chk(lanes == 128'h12345678, "R7 update copies group 0", lanes, 128'h12345678);

    run(cmdw(32'hA5, 8, 3'b001, 4'b0001), cyc, hi);
    chk(cyc == 32, "R3 8-bit shift duration", 128'(cyc), 128'd32);
    chk(rd_data[31:24] == 8'h78, "R4 returned bits in top byte", 128'(rd_data[31:24]), 128'h78);
    chk(rd_data[23:0] == 24'h0, "R4 shifted word moved down", 128'(rd_data[23:0]), 128'h0);

    run(cmdw(32'h0, 1, 3'b100, 4'b0001), cyc, hi);
    chk(cyc == 4, "R8 capture duration", 128'(cyc), 128'd4);
    run(cmdw(32'h0, 32, 3'b001, 4'b0001), cyc, hi);
    chk(rd_data[31:0] == 32'h12345678, "R8 capture reloads chain", 128'(rd_data[31:0]), 128'h12345678);

    // bypass group 0, div 1
    wr(1'b0, ctrlw(1, 0, 4'b0001));
    run(cmdw(32'h5, 4, 3'b001, 4'b0001), cyc, hi);
    chk(cyc == 32, "R2 div 1 step period", 128'(cyc), 128'd32);
    chk(rd_data[31:0] == 32'hA0000000, "R11 bypass one-bit delay", 128'(rd_data[31:0]), 128'hA0000000);
    wr(1'b0, ctrlw(0, 0, 4'b0000));
    run(cmdw(32'h0, 32, 3'b001, 4'b0001), cyc, hi);
    chk(rd_data[31:0] == 32'h0, "R11 bypassed chain unchanged", 128'(rd_data[31:0]), 128'h0);

    // group 2 via index and one-hot select
    wr(1'b0, ctrlw(0, 2, 4'b0000));
    run(cmdw(32'hCAFEF00D, 32, 3'b001, 4'b0100), cyc, hi);
    chk(rd_data[31:0] == 32'h0, "R12 return from indexed group", 128'(rd_data[31:0]), 128'h0);
    run(cmdw(32'h0, 1, 3'b010, 4'b0100), cyc, hi);
    chk(lanes[95:64] == 32'hCAFEF00D, "R12 selected group updated", 128'(lanes[95:64]), 128'hCAFEF00D);
    chk(lanes[31:0] == 32'h12345678, "R12 unselected group kept", 128'(lanes[31:0]), 128'h12345678);

    // writes while busy
    wr(1'b1, cmdw(32'h1, 32, 3'b001, 4'b0100));
    wr(1'b1, cmdw(32'hFFFFFFFF, 4, 3'b010, 4'b1111));
    wr(1'b0, ctrlw(7, 1, 4'b1111));
    wait_idle(cyc, hi);
    chk(rd_data[31:0] == 32'hCAFEF00D, "R9 busy command write ignored", 128'(rd_data[31:0]), 128'hCAFEF00D);
    chk(lanes[127:96] == 32'h0, "R9 ignored update had no effect", 128'(lanes[127:96]), 128'h0);
    rd_ctrl(v);
    chk(v == ctrlw(0, 2, 4'b0000), "R13 busy control write ignored", 128'(v), 128'(ctrlw(0, 2, 4'b0000)));

    // several command bits at once
    wr(1'b1, cmdw(32'h1, 1, 3'b111, 4'b0100));
    @(negedge clk);
    chk(rd_data[42:40] == 3'b001, "R10 shift wins priority", 128'(rd_data[42:40]), 128'h1);
    wait_idle(cyc, hi);
    chk(lanes[95:64] == 32'hCAFEF00D, "R10 update not run", 128'(lanes[95:64]), 128'hCAFEF00D);

    // largest exponent
    wr(1'b0, ctrlw(7, 2, 4'b0000));
    run(cmdw(32'h0, 1, 3'b001, 4'b0100), cyc, hi);
    chk(cyc == 512, "R2 div 7 step period", 128'(cyc), 128'd512);
    chk(hi == 256, "R2 div 7 high half", 128'(hi), 128'd256);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule